// File: doc/BRIEF.md
# End-of-Write Status Responder

This block forms the byte that a byte-wide nonvolatile memory port returns on a read. While an internal programming cycle is running, a host can read the device to find out whether the cycle has finished, and it has two ways to do so. It can read back the address it wrote last and watch the top data bit, which stays the inverse of the written value until programming ends. It can also read any address and watch bit 6, which changes level on every completed read while the device is busy and stops changing once it is idle. When no programming cycle is in progress, reads return the stored array byte unchanged.

The block sits between the array read path and the data pins. Its inputs are the busy flag from the programming timer, the active-low chip-select and read-enable pins, the read address, the address and data of the last write, and the array read byte. Its outputs are the read byte and a bus-drive enable. Two small state machines do the sequencing. The read-cycle machine has two states, `RD_IDLE` and `RD_OPEN`. Transition *open* goes from `RD_IDLE` to `RD_OPEN` when both control pins are low. Transition *close* goes from `RD_OPEN` back to `RD_IDLE` when either pin returns high, and it raises a one-cycle end-of-read pulse. The toggle machine has two states, `TG_LOW` and `TG_HIGH`. Transition *flip* moves it to the other state when an end-of-read pulse arrives while busy is high. Transition *hold* keeps it where it is in every other cycle. All output forming is combinational from the pins and these two state registers.

Top module: `eow_status_responder`

## Requirements
- R1: `rd_oe` is 1 exactly when `ce_n` and `oe_n` are both 0. Whenever `rd_oe` is 0, `rd_data` is all zeros.
- R2: While `busy` is 0 and the bus is driven, `rd_data` equals `arr_data` in every bit.
- R3: While `busy` is 1 and the bus is driven with `rd_addr` equal to `last_addr`, bit 7 of `rd_data` is the inverse of bit 7 of `last_data`.
- R4: While `busy` is 1 and the bus is driven with `rd_addr` different from `last_addr`, bit 7 of `rd_data` is 0.
- R5: While `busy` is 1 and the bus is driven, bit 6 of `rd_data` equals the toggle state (`TG_HIGH` reads as 1).
- R6: A read ends in the first clock after one in which both control pins were low and either pin is high. If `busy` is 1 at that clock, the toggle state changes once. A read held open for several cycles still changes it only once, and bit 6 stays constant while the read is held open.
- R7: While `busy` is 0 the toggle state holds. When busy rises again, bit 6 resumes from the value that was held.
- R8: While `busy` is 1, bits 5 down to 0 of `rd_data` are 0.
- R9: After reset the toggle state is `TG_LOW`, so the first busy read returns 0 on bit 6.
- R10: Pulses on `oe_n` while `ce_n` is 1 are not reads and leave the toggle state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | High while an internal programming cycle is running |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low read enable |
| rd_addr | input | ADDR_W (13) | Address of the current read |
| last_addr | input | ADDR_W (13) | Address of the last byte written |
| last_data | input | DATA_W (8) | Data of the last byte written |
| arr_data | input | DATA_W (8) | Byte read from the array |
| rd_data | output | DATA_W (8) | Byte returned to the host |
| rd_oe | output | 1 | Drive enable for the data pins |

## Verification
The bench targets the following corner cases:

- **Read held open for several cycles.** A design that advanced the toggle on every cycle of the read would make bit 6 flicker within one read and move by more than one step.
- **Read-enable pulses with chip select high.** A design that counted raw read-enable edges would advance the toggle without any real read taking place.
- **Busy dropped and raised between polls.** A design that reset the toggle when idle, or let it run while idle, would resume from the wrong level.
- **Bit 7 at addresses other than the last written one, and with both polarities of the written bit 7.** These cases expose a missing address compare or a missing inversion.
- **Reset in the middle of a run.** This exposes a toggle that does not return to its low state.

// File: rtl/eow_pkg.sv
package eow_pkg;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_OPEN = 1'b1
    } rd_state_e;

    typedef enum logic {
        TG_LOW  = 1'b0,
        TG_HIGH = 1'b1
    } tg_state_e;

endpackage

// File: rtl/eow_read_fsm.sv
module eow_read_fsm
    import eow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic bus_en,
    output logic rd_end
);

    rd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // next state: open when both strobes low, close when either returns high
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (!ce_n && !oe_n) state_d = RD_OPEN;
            RD_OPEN: if (ce_n || oe_n)   state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        bus_en = !ce_n && !oe_n;
        rd_end = 1'b0;
        unique case (state_q)
            RD_IDLE: rd_end = 1'b0;
            RD_OPEN: rd_end = ce_n || oe_n;
        endcase
    end

endmodule

// File: rtl/eow_toggle_fsm.sv
module eow_toggle_fsm
    import eow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_end,
    output logic tgl
);

    tg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TG_LOW;
        else        state_q <= state_d;
    end

    // flip on a finished read while busy, hold otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TG_LOW:  if (busy && rd_end) state_d = TG_HIGH;
            TG_HIGH: if (busy && rd_end) state_d = TG_LOW;
        endcase
    end

    always_comb begin
        unique case (state_q)
            TG_LOW:  tgl = 1'b0;
            TG_HIGH: tgl = 1'b1;
        endcase
    end

endmodule

// File: rtl/eow_data_mux.sv
module eow_data_mux #(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = 7,
    parameter int TGL_BIT  = 6
) (
    input  logic              busy,
    input  logic              bus_en,
    input  logic              tgl,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic              last_poll,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic addr_hit;
    assign addr_hit = (rd_addr == last_addr);

    // status byte while busy: poll bit, toggle bit, everything else zero
    always_comb begin
        rd_data = '0;
        if (bus_en) begin
            if (!busy) begin
                rd_data = arr_data;
            end else begin
                rd_data[TGL_BIT] = tgl;
                if (addr_hit) rd_data[POLL_BIT] = ~last_poll;
            end
        end
    end

endmodule

// File: rtl/eow_status_responder.sv
module eow_status_responder #(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = 7,
    parameter int TGL_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);

    logic bus_en;
    logic rd_end;
    logic tgl_q;
    logic last_unused;

    // only the polled bit of the written byte is needed
    assign last_unused = ^last_data;

    eow_read_fsm u_read (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .bus_en (bus_en),
        .rd_end (rd_end)
    );

    eow_toggle_fsm u_toggle (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (busy),
        .rd_end (rd_end),
        .tgl    (tgl_q)
    );

    eow_data_mux #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TGL_BIT  (TGL_BIT)
    ) u_mux (
        .busy      (busy),
        .bus_en    (bus_en),
        .tgl       (tgl_q),
        .rd_addr   (rd_addr),
        .last_addr (last_addr),
        .last_poll (last_data[POLL_BIT]),
        .arr_data  (arr_data),
        .rd_data   (rd_data)
    );

    assign rd_oe = bus_en;

endmodule

// File: rtl/eow_status_checker.sv
module eow_status_checker #(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = 7,
    parameter int TGL_BIT  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              ce_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] last_addr,
    input logic [DATA_W-1:0] last_data,
    input logic [DATA_W-1:0] arr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_oe,
    input logic              tgl
);

    assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe |-> rd_data == '0);

    assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_oe) |-> rd_data == arr_data);

    assert_poll_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_oe && rd_addr == last_addr) |-> rd_data[POLL_BIT] != last_data[POLL_BIT]);

    assert_toggle_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_oe) |-> rd_data[TGL_BIT] == tgl);

    assert_toggle_steady_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n) |=> $stable(tgl));

    assert_toggle_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tgl));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rd_data[TGL_BIT-1:0] == '0);

    assert_no_deselected_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && $past(ce_n)) |=> $stable(tgl));

endmodule

bind eow_status_responder eow_status_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TGL_BIT  (TGL_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .rd_addr   (rd_addr),
    .last_addr (last_addr),
    .last_data (last_data),
    .arr_data  (arr_data),
    .rd_data   (rd_data),
    .rd_oe     (rd_oe),
    .tgl       (tgl_q)
);

// File: tb/tb_eow_status_responder.sv
module tb_eow_status_responder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [12:0] rd_addr = '0;
    logic [12:0] last_addr = 13'h0ABC;
    logic [7:0]  last_data = 8'h5A;
    logic [7:0]  arr_data = '0;
    logic [7:0]  rd_data;
    logic        rd_oe;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    eow_status_responder dut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .ce_n(ce_n), .oe_n(oe_n),
        .rd_addr(rd_addr), .last_addr(last_addr), .last_data(last_data),
        .arr_data(arr_data), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    typedef struct packed {
        logic        b;
        logic [12:0] a;
        logic [7:0]  arr;
        logic [7:0]  exp;
    } vec_t;

    // last_addr 0ABC, last_data 5A (bit 7 = 0); toggle starts low after reset
    localparam vec_t VECS [10] = '{
        '{1'b0, 13'h0ABC, 8'h5A, 8'h5A},  // R2 idle read
        '{1'b1, 13'h0ABC, 8'h5A, 8'h80},  // R3 R5 R9 first poll bit6=0
        '{1'b1, 13'h0ABC, 8'h5A, 8'hC0},  // R6 flipped
        '{1'b1, 13'h0001, 8'hFF, 8'h00},  // R4 R8 other address
        '{1'b1, 13'h0001, 8'hFF, 8'h40},  // R4 R6
        '{1'b0, 13'h0ABC, 8'h5A, 8'h5A},  // R2
        '{1'b0, 13'h0ABC, 8'hA5, 8'hA5},  // R2 R7
        '{1'b1, 13'h0ABC, 8'h00, 8'h80},  // R7 resumes low
        '{1'b0, 13'h0123, 8'h33, 8'h33},  // R7 idle with toggle high
        '{1'b1, 13'h0ABC, 8'h00, 8'hC0}   // R7 resumes high
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic poll(input logic b, input logic [12:0] a, input logic [7:0] arr,
                        output logic [7:0] got, output logic drv);
        @(negedge clk);
        busy = b; rd_addr = a; arr_data = arr; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        got = rd_data; drv = rd_oe;
        oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic       drv;

        repeat (3) @(negedge clk);
        check8("R1 reset drive", {7'd0, rd_oe}, 8'h00);
        check8("R1 reset data", rd_data, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) begin
            poll(VECS[i].b, VECS[i].a, VECS[i].arr, got, drv);
            check8($sformatf("R2-R9 vector %0d", i), got, VECS[i].exp);
            check8("R1 drive in read", {7'd0, drv}, 8'h01);
        end
        // toggle now low

        // R1: only one strobe low
        @(negedge clk); busy = 1'b1; rd_addr = 13'h0ABC; ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        check8("R1 ce high", {rd_data[7:1], rd_oe}, 8'h00);
        ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        check8("R1 oe high", {rd_data[7:1], rd_oe}, 8'h00);
        ce_n = 1'b1;

        // R10: read-enable pulses with chip deselected
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); oe_n = 1'b0;
            @(negedge clk); oe_n = 1'b1;
        end
        poll(1'b1, 13'h0ABC, 8'h00, got, drv);
        check8("R10 no step when deselected", got, 8'h80);
        // toggle high

        // R6: long read
        @(negedge clk); busy = 1'b1; rd_addr = 13'h0ABC; ce_n = 1'b0; oe_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check8("R6 steady while open", rd_data, 8'hC0);
        end
        oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        poll(1'b1, 13'h0ABC, 8'h00, got, drv);
        check8("R6 single step after long read", got, 8'h80);
        // toggle high

        // R3: written bit 7 = 1
        last_data = 8'hC3;
        poll(1'b1, 13'h0ABC, 8'h00, got, drv);
        check8("R3 inverted one", got, 8'h40);
        // toggle low
        poll(1'b1, 13'h0ABC, 8'h00, got, drv);
        check8("R3 inverted one low toggle", got, 8'h00);
        // toggle high

        // R9: reset mid run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        poll(1'b1, 13'h0ABC, 8'h00, got, drv);
        check8("R9 toggle low after reset", got, 8'h00);
        poll(1'b1, 13'h0ABC, 8'h00, got, drv);
        check8("R9 R6 steps after reset", got, 8'h40);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule